// File: doc/BRIEF.md
# Page-Latch Flash Programming Controller

This block writes an on-chip non-volatile array through a page-sized set of column latches. Software first sets a map bit in an 8-bit control register. While that bit is set, each write on the data-store port places one byte in the latch at the address's low seven bits and marks that byte as loaded. The page number is taken from the first such write.

A two-write unlock on the control register then starts an operation. The write carrying the launch key also selects one of three target spaces: the user array, an extra row, or a small fuse-bit area. The controller scans the latch set twice. The first pass erases every loaded location to FFh. The second pass programs each loaded location with its latched byte. Locations that were never loaded keep their contents, so no page or block erase is needed beforehand. A busy flag covers the whole operation.

The array is modelled as a register file. Erase and program times are parameterised cycle counts. A read port returns any byte of the three spaces. When an enable input is high, the read port maps a boot region over the top of the address space.

Top module: `flash_page_prog`

## Requirements
- R1: After reset, busy_o is 0 and every byte of the user, extra-row and fuse spaces reads FFh.
- R2: A data-port write reaches the latches only while the map bit (control bit 0) is 1. A data-port write made while that bit is 0 leaves the target byte unchanged after a later operation.
- R3: A control write with bits [7:4] = 5h, followed by a control write with bits [7:4] = Ah, starts an operation. The target space comes from bits [2:1] of the second write.
- R4: Any data-port write or other control write between the 5h write and the Ah write cancels the unlock, and the Ah write then starts nothing.
- R5: The target field selects 00 = user space, 01 = extra row and 10 = fuse space. 11 starts nothing, and the loaded latches are kept.
- R6: An operation changes only the locations that were loaded. Every other byte of the page and of the space keeps its value.
- R7: Each loaded location ends up holding exactly its latched byte, whatever it held before, because it is erased to FFh before it is programmed.
- R8: busy_o rises on the cycle after the launching write. It stays high for 2*(PAGE_BYTES-N) + N*(ERASE_CYC+PROG_CYC) + 1 cycles, where N is the number of loaded bytes.
- R9: When an operation completes, all loaded flags are cleared. A following launch with no new loads changes no byte and lasts 2*PAGE_BYTES+1 cycles.
- R10: While busy_o is high, control writes and data-port writes are ignored. This applies to the map bit, to the unlock sequence and to the latches.
- R11: The page is given by address bits [15:7] of the first latch write after the latch set was empty. Later writes use only bits [6:0]. A user-space byte lives at address (page mod USER_PAGES)*128 + index, and reads use the address modulo the user-space size.
- R12: With boot_map_i high, a user-space read at an address of F800h or above returns the low address byte XOR A5h. With boot_map_i low, the same read returns the user array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control data: [7:4] key, [2:1] target, [0] map |
| dw_we_i | input | 1 | Data-store port write strobe |
| dw_addr_i | input | AW | Data-store address |
| dw_data_i | input | 8 | Data-store byte |
| boot_map_i | input | 1 | Maps the boot region over the top of the address space |
| rd_space_i | input | 2 | Read space: 00 user, 01 extra row, 10 fuse |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| busy_o | output | 1 | Erase/program operation in progress |

## Verification
The assertions assume the strobes are known at every clock edge and that each write lasts a single cycle. They also assume control and data writes arrive in separate cycles, as they would from a CPU that issues one access at a time. The bench drives every write from a task that raises a strobe for one cycle on a falling edge and never raises both strobes together. It reads results only through the read port and the busy flag, and it makes writes during busy only to prove they are ignored.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    SP_USER = 2'b00,
    SP_XROW = 2'b01,
    SP_FUSE = 2'b10,
    SP_NONE = 2'b11
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_PROG  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  localparam logic [3:0] KEY_ARM = 4'h5;
  localparam logic [3:0] KEY_GO  = 4'hA;
  localparam logic [7:0] ERASED  = 8'hFF;
  localparam logic [7:0] BOOT_XOR = 8'hA5;
endpackage

// File: rtl/fpc_ctl_reg.sv
module fpc_ctl_reg
  import fpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic [7:0] ctl_wdata_i,
  input  logic       dw_we_i,
  input  logic       busy_i,
  output logic       map_o,
  output logic       launch_o,
  output space_e     mode_o
);
  logic armed_q;
  logic map_q;
  logic ctl_acc;
  logic [3:0] key;

  assign key     = ctl_wdata_i[7:4];
  assign ctl_acc = ctl_we_i && !busy_i;
  assign mode_o  = space_e'(ctl_wdata_i[2:1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      map_q   <= 1'b0;
    end else if (busy_i) begin
      armed_q <= 1'b0;
    end else if (ctl_we_i) begin
      armed_q <= (key == KEY_ARM);
      map_q   <= ctl_wdata_i[0];
    end else if (dw_we_i) begin
      armed_q <= 1'b0;
    end
  end

  assign map_o    = map_q;
  assign launch_o = ctl_acc && armed_q && (key == KEY_GO) && (mode_o != SP_NONE);

  // R3
  arm_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(ctl_we_i && ctl_wdata_i[7:4] == KEY_ARM));

  // R4
  abort_on_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && dw_we_i && !ctl_we_i |=> !armed_q);

  // R10
  map_hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(map_q));
endmodule

// File: rtl/fpc_latch_buf.sv
module fpc_latch_buf #(
  parameter int PAGE_BYTES = 128,
  parameter int AW         = 16,
  localparam int IW        = $clog2(PAGE_BYTES),
  localparam int PW        = AW - IW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [7:0]            data_i,
  input  logic                  busy_i,
  input  logic                  clr_i,
  input  logic [IW-1:0]         rd_idx_i,
  output logic [PAGE_BYTES-1:0] vld_o,
  output logic [7:0]            rd_data_o,
  output logic [PW-1:0]         page_o
);
  logic [PAGE_BYTES-1:0] vld_q;
  logic [PW-1:0]         page_q;
  logic [7:0]            mem_q [PAGE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      page_q <= '0;
    end else if (clr_i) begin
      vld_q <= '0;
    end else if (we_i) begin
      vld_q[addr_i[IW-1:0]] <= 1'b1;
      if (vld_q == '0) page_q <= addr_i[AW-1:IW];
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i[IW-1:0]] <= data_i;
  end

  assign vld_o     = vld_q;
  assign page_o    = page_q;
  assign rd_data_o = mem_q[rd_idx_i];

  // R10
  vld_hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !clr_i |=> $stable(vld_q));

  // R9
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vld_q == '0));

  // R11
  page_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q != '0) && !clr_i |=> $stable(page_q));
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int ERASE_CYC  = 16,
  parameter int PROG_CYC   = 32,
  localparam int IW        = $clog2(PAGE_BYTES),
  localparam int MAXC      = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
  localparam int CW        = $clog2(MAXC + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  launch_i,
  input  space_e                mode_i,
  input  logic [PAGE_BYTES-1:0] vld_i,
  input  logic [7:0]            lat_data_i,
  output logic                  busy_o,
  output logic                  clr_o,
  output logic [IW-1:0]         idx_o,
  output logic                  wr_en_o,
  output space_e                wr_space_o,
  output logic [7:0]            wr_data_o
);
  seq_state_e st_q;
  space_e     mode_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_cnt;
  logic scan, hit, step, idx_last;

  assign scan     = (st_q == ST_ERASE) || (st_q == ST_PROG);
  assign hit      = vld_i[idx_q];
  assign last_cnt = (st_q == ST_ERASE) ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
  assign step     = !hit || (cnt_q == last_cnt);
  assign idx_last = (idx_q == IW'(PAGE_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= SP_USER;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (launch_i) begin
          st_q   <= ST_ERASE;
          mode_q <= mode_i;
          idx_q  <= '0;
          cnt_q  <= '0;
        end
        ST_ERASE, ST_PROG: begin
          if (step) begin
            cnt_q <= '0;
            if (idx_last) begin
              idx_q <= '0;
              st_q  <= (st_q == ST_ERASE) ? ST_PROG : ST_DONE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign clr_o      = (st_q == ST_DONE);
  assign idx_o      = idx_q;
  assign wr_en_o    = scan && hit && (cnt_q == last_cnt);
  assign wr_space_o = mode_q;
  assign wr_data_o  = (st_q == ST_ERASE) ? ERASED : lat_data_i;

  // R8
  busy_on_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> busy_o);

  // R5
  no_go_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> mode_i != SP_NONE);

  // R10
  no_launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !launch_i);

  // R7
  prog_after_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clr_o) |-> $past(st_q == ST_PROG));
endmodule

// File: rtl/fpc_array.sv
module fpc_array
  import fpc_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int USER_PAGES = 4,
  parameter int FUSE_BYTES = 8,
  parameter int AW         = 16,
  parameter int BOOT_BASE  = 'hF800,
  localparam int IW        = $clog2(PAGE_BYTES),
  localparam int PW        = AW - IW,
  localparam int USER_BYTES = USER_PAGES * PAGE_BYTES,
  localparam int UAW       = $clog2(USER_BYTES),
  localparam int FW        = $clog2(FUSE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  space_e        wr_space_i,
  input  logic [PW-1:0] wr_page_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic          boot_map_i,
  input  logic [1:0]    rd_space_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] user_q [USER_BYTES];
  logic [7:0] xrow_q [PAGE_BYTES];
  logic [7:0] fuse_q [FUSE_BYTES];
  logic [AW-1:0] wfull;
  logic in_boot;

  assign wfull = {wr_page_i, wr_idx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < USER_BYTES; i++) user_q[i] <= ERASED;
      for (int i = 0; i < PAGE_BYTES; i++) xrow_q[i] <= ERASED;
      for (int i = 0; i < FUSE_BYTES; i++) fuse_q[i] <= ERASED;
    end else if (wr_en_i) begin
      unique case (wr_space_i)
        SP_USER: user_q[wfull[UAW-1:0]] <= wr_data_i;
        SP_XROW: xrow_q[wr_idx_i] <= wr_data_i;
        SP_FUSE: if (wr_idx_i < IW'(FUSE_BYTES)) fuse_q[wr_idx_i[FW-1:0]] <= wr_data_i;
        default: ;
      endcase
    end
  end

  assign in_boot = boot_map_i && (rd_addr_i >= AW'(BOOT_BASE));

  always_comb begin
    unique case (rd_space_i)
      SP_USER: rd_data_o = in_boot ? (rd_addr_i[7:0] ^ BOOT_XOR) : user_q[rd_addr_i[UAW-1:0]];
      SP_XROW: rd_data_o = xrow_q[rd_addr_i[IW-1:0]];
      SP_FUSE: rd_data_o = fuse_q[rd_addr_i[FW-1:0]];
      default: rd_data_o = ERASED;
    endcase
  end

  // R5
  no_write_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> wr_space_i != SP_NONE);
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import fpc_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int USER_PAGES = 4,
  parameter int FUSE_BYTES = 8,
  parameter int AW         = 16,
  parameter int ERASE_CYC  = 16,
  parameter int PROG_CYC   = 32,
  parameter int BOOT_BASE  = 'hF800,
  localparam int IW        = $clog2(PAGE_BYTES),
  localparam int PW        = AW - IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [7:0]    ctl_wdata_i,
  input  logic          dw_we_i,
  input  logic [AW-1:0] dw_addr_i,
  input  logic [7:0]    dw_data_i,
  input  logic          boot_map_i,
  input  logic [1:0]    rd_space_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o
);
  logic                  busy, map, launch, clr, lat_we, wr_en;
  space_e                mode, wr_space;
  logic [PAGE_BYTES-1:0] vld;
  logic [7:0]            lat_data, wr_data;
  logic [PW-1:0]         page;
  logic [IW-1:0]         idx;

  assign lat_we = dw_we_i && map && !busy;
  assign busy_o = busy;

  fpc_ctl_reg u_ctl (
    .clk_i, .rst_ni,
    .ctl_we_i, .ctl_wdata_i, .dw_we_i,
    .busy_i   (busy),
    .map_o    (map),
    .launch_o (launch),
    .mode_o   (mode)
  );

  fpc_latch_buf #(.PAGE_BYTES(PAGE_BYTES), .AW(AW)) u_lat (
    .clk_i, .rst_ni,
    .we_i      (lat_we),
    .addr_i    (dw_addr_i),
    .data_i    (dw_data_i),
    .busy_i    (busy),
    .clr_i     (clr),
    .rd_idx_i  (idx),
    .vld_o     (vld),
    .rd_data_o (lat_data),
    .page_o    (page)
  );

  fpc_seq #(.PAGE_BYTES(PAGE_BYTES), .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC)) u_seq (
    .clk_i, .rst_ni,
    .launch_i   (launch),
    .mode_i     (mode),
    .vld_i      (vld),
    .lat_data_i (lat_data),
    .busy_o     (busy),
    .clr_o      (clr),
    .idx_o      (idx),
    .wr_en_o    (wr_en),
    .wr_space_o (wr_space),
    .wr_data_o  (wr_data)
  );

  fpc_array #(.PAGE_BYTES(PAGE_BYTES), .USER_PAGES(USER_PAGES), .FUSE_BYTES(FUSE_BYTES),
              .AW(AW), .BOOT_BASE(BOOT_BASE)) u_arr (
    .clk_i, .rst_ni,
    .wr_en_i    (wr_en),
    .wr_space_i (wr_space),
    .wr_page_i  (page),
    .wr_idx_i   (idx),
    .wr_data_i  (wr_data),
    .boot_map_i,
    .rd_space_i,
    .rd_addr_i,
    .rd_data_o
  );
endmodule

// File: tb/flash_page_prog_tb.sv
`timescale 1ns/1ps
module flash_page_prog_tb;
  localparam int E = 3;
  localparam int P = 5;
  localparam int PB = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        dw_we = 1'b0;
  logic [15:0] dw_addr = '0;
  logic [7:0]  dw_data = '0;
  logic        boot_map = 1'b0;
  logic [1:0]  rd_space = 2'b00;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_page_prog #(.ERASE_CYC(E), .PROG_CYC(P)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata),
    .dw_we_i(dw_we), .dw_addr_i(dw_addr), .dw_data_i(dw_data),
    .boot_map_i(boot_map), .rd_space_i(rd_space), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy)
  );

  function automatic int busy_len(int n);
    return 2 * (PB - n) + n * (E + P) + 1;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ctl_wr(logic [7:0] d);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic dw_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); dw_we = 1'b1; dw_addr = a; dw_data = d;
    @(negedge clk); dw_we = 1'b0;
  endtask

  task automatic launch(logic [1:0] mode, logic map_bit);
    ctl_wr(8'h50);
    ctl_wr({4'hA, 1'b0, mode, map_bit});
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic rd(logic [1:0] sp, logic [15:0] a, output logic [7:0] d);
    rd_space = sp; rd_addr = a; #1; d = rd_data;
  endtask

  task automatic chk_byte(string req, logic [1:0] sp, logic [15:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(sp, a, d);
    chk(req, $sformatf("space %0d addr %h", sp, a), int'(d), int'(exp));
  endtask

  task automatic t_reset;
    chk("R1", "busy after reset", int'(busy), 0);
    chk_byte("R1", 2'b00, 16'h0000, 8'hFF);
    chk_byte("R1", 2'b00, 16'h01FF, 8'hFF);
    chk_byte("R1", 2'b01, 16'h0005, 8'hFF);
    chk_byte("R1", 2'b10, 16'h0000, 8'hFF);
  endtask

  task automatic t_partial;
    int cyc;
    ctl_wr(8'h01);
    dw_wr(16'h0103, 8'hC3);
    dw_wr(16'h010A, 8'h3A);
    dw_wr(16'h017F, 8'h00);
    ctl_wr(8'h00);
    launch(2'b00, 1'b0);
    chk("R8", "busy after launch", int'(busy), 1);
    wait_idle(cyc);
    chk("R8", "busy length 3 bytes", cyc, busy_len(3));
    chk_byte("R3", 2'b00, 16'h0103, 8'hC3);
    chk_byte("R11", 2'b00, 16'h010A, 8'h3A);
    chk_byte("R7", 2'b00, 16'h017F, 8'h00);
    chk_byte("R6", 2'b00, 16'h0104, 8'hFF);
    chk_byte("R6", 2'b00, 16'h0003, 8'hFF);
  endtask

  task automatic t_overwrite;
    int cyc;
    ctl_wr(8'h01);
    dw_wr(16'h0103, 8'h3C);
    ctl_wr(8'h00);
    launch(2'b00, 1'b0);
    wait_idle(cyc);
    chk("R8", "busy length 1 byte", cyc, busy_len(1));
    chk_byte("R7", 2'b00, 16'h0103, 8'h3C);
    chk_byte("R6", 2'b00, 16'h010A, 8'h3A);
    chk_byte("R6", 2'b00, 16'h017F, 8'h00);
  endtask

  task automatic t_map_off;
    int cyc;
    ctl_wr(8'h00);
    dw_wr(16'h0000, 8'h99);
    ctl_wr(8'h01);
    dw_wr(16'h0002, 8'h77);
    ctl_wr(8'h00);
    launch(2'b00, 1'b0);
    wait_idle(cyc);
    chk("R2", "busy length map test", cyc, busy_len(1));
    chk_byte("R2", 2'b00, 16'h0000, 8'hFF);
    chk_byte("R2", 2'b00, 16'h0002, 8'h77);
  endtask

  task automatic t_abort;
    int cyc;
    ctl_wr(8'h01);
    dw_wr(16'h0183, 8'hAB);
    ctl_wr(8'h00);
    ctl_wr(8'h50);
    dw_wr(16'h0000, 8'h12);
    ctl_wr(8'hA0);
    repeat (3) @(negedge clk);
    chk("R4", "busy after data write between keys", int'(busy), 0);
    ctl_wr(8'h50);
    ctl_wr(8'h00);
    ctl_wr(8'hA0);
    repeat (3) @(negedge clk);
    chk("R4", "busy after ctl write between keys", int'(busy), 0);
    chk_byte("R4", 2'b00, 16'h0183, 8'hFF);
    launch(2'b00, 1'b0);
    wait_idle(cyc);
    chk("R3", "busy length after clean unlock", cyc, busy_len(1));
    chk_byte("R3", 2'b00, 16'h0183, 8'hAB);
    chk_byte("R2", 2'b00, 16'h0000, 8'hFF);
  endtask

  task automatic t_modes;
    int cyc;
    ctl_wr(8'h01);
    dw_wr(16'h0005, 8'hE5);
    ctl_wr(8'h00);
    launch(2'b01, 1'b0);
    wait_idle(cyc);
    chk_byte("R5", 2'b01, 16'h0005, 8'hE5);
    chk_byte("R5", 2'b00, 16'h0005, 8'hFF);
    ctl_wr(8'h01);
    dw_wr(16'h0002, 8'hF2);
    ctl_wr(8'h00);
    launch(2'b10, 1'b0);
    wait_idle(cyc);
    chk_byte("R5", 2'b10, 16'h0002, 8'hF2);
    chk_byte("R5", 2'b01, 16'h0002, 8'hFF);
    ctl_wr(8'h01);
    dw_wr(16'h0007, 8'h5E);
    ctl_wr(8'h00);
    launch(2'b11, 1'b0);
    repeat (3) @(negedge clk);
    chk("R5", "busy after target 11", int'(busy), 0);
    chk_byte("R5", 2'b00, 16'h0007, 8'hFF);
    chk_byte("R5", 2'b01, 16'h0007, 8'hFF);
    chk_byte("R5", 2'b10, 16'h0007, 8'hFF);
    launch(2'b01, 1'b0);
    wait_idle(cyc);
    chk("R5", "latch kept after target 11", cyc, busy_len(1));
    chk_byte("R5", 2'b01, 16'h0007, 8'h5E);
  endtask

  task automatic t_empty;
    int cyc;
    launch(2'b00, 1'b0);
    wait_idle(cyc);
    chk("R9", "busy length empty", cyc, busy_len(0));
    chk_byte("R9", 2'b00, 16'h0103, 8'h3C);
    chk_byte("R9", 2'b00, 16'h0007, 8'hFF);
  endtask

  task automatic t_busy_ignore;
    int cyc;
    ctl_wr(8'h01);
    dw_wr(16'h0001, 8'h11);
    ctl_wr(8'h00);
    launch(2'b00, 1'b1);
    dw_wr(16'h0014, 8'h22);
    ctl_wr(8'h00);
    ctl_wr(8'h50);
    ctl_wr(8'hA0);
    wait_idle(cyc);
    chk_byte("R10", 2'b00, 16'h0001, 8'h11);
    dw_wr(16'h0015, 8'h33);
    launch(2'b00, 1'b0);
    wait_idle(cyc);
    chk("R10", "only post-busy load counted", cyc, busy_len(1));
    chk_byte("R10", 2'b00, 16'h0014, 8'hFF);
    chk_byte("R10", 2'b00, 16'h0015, 8'h33);
  endtask

  task automatic t_page_capture;
    int cyc;
    ctl_wr(8'h01);
    dw_wr(16'h0080, 8'h5C);
    dw_wr(16'h0185, 8'h6D);
    ctl_wr(8'h00);
    launch(2'b00, 1'b0);
    wait_idle(cyc);
    chk_byte("R11", 2'b00, 16'h0080, 8'h5C);
    chk_byte("R11", 2'b00, 16'h0085, 8'h6D);
    chk_byte("R11", 2'b00, 16'h0185, 8'hFF);
    chk_byte("R11", 2'b00, 16'hF885, 8'h6D);
  endtask

  task automatic t_boot;
    boot_map = 1'b1;
    chk_byte("R12", 2'b00, 16'hF810, 8'hB5);
    chk_byte("R12", 2'b00, 16'hF802, 8'hA7);
    chk_byte("R12", 2'b00, 16'hF7FF, 8'hFF);
    chk_byte("R12", 2'b00, 16'h0002, 8'h77);
    boot_map = 1'b0;
    chk_byte("R12", 2'b00, 16'hF802, 8'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_partial;
    t_overwrite;
    t_map_off;
    t_abort;
    t_modes;
    t_empty;
    t_busy_ignore;
    t_page_capture;
    t_boot;
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule